// File: doc/BRIEF.md
# Ethernet Receive Bit-Stream Framer

This block sits behind the line decoder of an Ethernet receiver. It takes the recovered serial bit stream, the recovered clock and a carrier-sense level. While carrier is up it hunts for the end of the preamble, which is two 1 bits in a row. It then packs the following bits, least-significant bit first, into octets, and pushes each octet into a small show-ahead receive FIFO. A downstream buffering engine drains that FIFO.

When carrier falls, the framer closes the frame. It presents a five-bit status word together with a one-cycle done strobe. The status covers a frame check sequence failure, a misaligned tail, a short frame, a FIFO overrun and an overall reject verdict. Address comparison, buffer availability and collision detection are done elsewhere and arrive here as level flags. Two enables decide whether collisions and frame errors count toward rejection.

While the node is itself transmitting, the looped-back frame passes through the same path in a monitor mode. The frame check and the status are computed as usual, but nothing is written to the FIFO.

Top module: `mac_rx_framer`

## Requirements
- R1: While carrier is high and no frame is open, the block waits for two consecutive 1 bits. Until it sees them, no FIFO write happens, `frame_done` stays low when carrier falls, and `frame_stat` keeps its previous value.
- R2: After the delimiter, bits are packed least-significant first. Each complete octet is written to a 32-entry FIFO in arrival order. `fifo_dout` always shows the oldest entry, and `fifo_rd` removes it.
- R3: A frame closes on the first clock edge at which carrier is low. `frame_done` is high for exactly the one cycle after that edge, and `frame_stat` then holds the frame's status until the next delimiter.
- R4: `frame_stat[0]` (check error) is set when the CRC-32 (polynomial 0x04C11DB7, all-ones preset) run over every complete octet after the delimiter does not leave the residue 0xC704DD7B.
- R5: `frame_stat[1]` (alignment error) is set when 1 to 7 bits remain after the last complete octet and `frame_stat[0]` is also set.
- R6: `frame_stat[2]` (runt) is set when fewer than 64 complete octets followed the delimiter, the check sequence included.
- R7: When an octet completes while the FIFO is full, that octet is dropped and no further octet of the frame is written. `frame_stat[3]` and `frame_stat[4]` are then both set.
- R8: If `addr_miss` or `no_buf` is high during a bit of the frame, no octet completing at or after that bit is written, and `frame_stat[4]` (rejected) is set.
- R9: With `rej_coll_en` high, `coll` acts as in R8. With `rej_coll_en` low, `coll` has no effect on writes or status.
- R10: With `rej_err_en` high, a check error or a runt also sets `frame_stat[4]`, while the frame's octets are still written. With it low, those errors leave `frame_stat[4]` clear.
- R11: If `self_rx` is high when the delimiter is seen, the frame writes nothing to the FIFO, and its status bits are produced as in R4 to R6.
- R12: `frame_stat` reads zero in the cycle after the delimiter is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial receive data |
| carrier | input | 1 | Carrier sense level |
| self_rx | input | 1 | Node is transmitting; treat the frame as a monitored loopback |
| addr_miss | input | 1 | Destination address did not match |
| no_buf | input | 1 | No receive buffer is available |
| coll | input | 1 | Collision seen on the medium |
| rej_coll_en | input | 1 | Collisions cause rejection |
| rej_err_en | input | 1 | Check errors and runts cause rejection |
| fifo_rd | input | 1 | Pop the oldest FIFO entry |
| fifo_dout | output | 8 | Oldest FIFO entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_level | output | 6 | Number of entries in the FIFO |
| frame_done | output | 1 | One-cycle strobe when a frame closes |
| frame_stat | output | 5 | {rejected, overrun, runt, alignment error, check error} |

## Verification
A slipped bit counter shows up as wrong bytes at `fifo_dout` within the very octet it affects. A stale check register, or one that was never preset, flips `frame_stat[0]` at the done strobe of the frame concerned. A missed delimiter or a lost end of frame shows as a missing or doubled `frame_done`, so the bench counts strobes rather than merely sampling them. Sticky reject and overrun state that fails to clear or fails to set shows at the FIFO level and in the status word of the same frame or the next one. For that reason the bench runs frames back to back across a sweep of lengths around the runt boundary and of tail bit counts.

// File: rtl/mac_rx_pkg.sv
package mac_rx_pkg;

   localparam int OCT_W = 8;

   // CRC-32 in a right-shifting register: reflected polynomial and residue
   localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
   localparam logic [31:0] CRC_GOOD_R = 32'hDEBB20E3;
   localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_RECV = 1'b1
   } rx_state_e;

   typedef struct packed {
      logic rejected;
      logic overrun;
      logic runt;
      logic align_err;
      logic crc_err;
   } rx_stat_t;

   function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic d);
      logic fb;
      fb = c[0] ^ d;
      crc_bit = {1'b0, c[31:1]} ^ (fb ? CRC_POLY_R : 32'h0);
   endfunction

endpackage

// File: rtl/rx_crc32_chk.sv
module rx_crc32_chk
   import mac_rx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic en,
   input  logic din,
   input  logic oct_last,
   output logic oct_good
);

   logic [31:0] crc_q;
   logic [31:0] crc_d;

   assign crc_d = crc_bit(crc_q, din);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q    <= CRC_PRESET;
         oct_good <= 1'b0;
      end else if (init) begin
         crc_q    <= CRC_PRESET;
         oct_good <= 1'b0;
      end else if (en) begin
         crc_q <= crc_d;
         if (oct_last) begin
            oct_good <= (crc_d == CRC_GOOD_R);
         end
      end
   end

   AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (crc_q == CRC_PRESET && !oct_good)); // R4

endmodule

// File: rtl/rx_deser.sv
module rx_deser #(
   parameter int W         = 8,
   parameter bit LSB_FIRST = 1'b1,
   localparam int CW       = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          din,
   output logic          oct_vld,
   output logic [W-1:0]  oct_data,
   output logic [CW-1:0] part_cnt
);

   logic [W-1:0]  sr_q;
   logic [CW-1:0] cnt_q;
   logic          last;

   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("rx_deser: W must be a power of two of at least 2");
   end

   assign last     = (cnt_q == CW'(W - 1));
   assign oct_vld  = en && last;
   assign part_cnt = cnt_q;

   if (LSB_FIRST) begin : g_lsb
      assign oct_data = {din, sr_q[W-1:1]};
      always_ff @(posedge clk) begin
         if (!rst_n)  sr_q <= '0;
         else if (en) sr_q <= {din, sr_q[W-1:1]};
      end
   end else begin : g_msb
      assign oct_data = {sr_q[W-2:0], din};
      always_ff @(posedge clk) begin
         if (!rst_n)  sr_q <= '0;
         else if (en) sr_q <= {sr_q[W-2:0], din};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (en)       cnt_q <= last ? '0 : cnt_q + 1'b1;
   end

   AST_OCTET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      oct_vld |=> (part_cnt == '0)); // R2

endmodule

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [W-1:0]  din,
   input  logic          rd,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [LW-1:0] level
);

   logic [LW-1:0]      wp_q;
   logic [LW-1:0]      rp_q;
   logic [DEPTH*W-1:0] flat;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rx_sync_fifo: DEPTH must be a power of two of at least 2");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr && wp_q[AW-1:0] == AW'(i)) q <= din;
      end
      assign flat[i*W +: W] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (wr) wp_q <= wp_q + 1'b1;
         if (rd) rp_q <= rp_q + 1'b1;
      end
   end

   assign empty = (wp_q == rp_q);
   assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign level = wp_q - rp_q;
   assign dout  = flat[W*int'(rp_q[AW-1:0]) +: W];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !full); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> !empty); // R2
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH)); // R2

endmodule

// File: rtl/mac_rx_framer.sv
module mac_rx_framer
   import mac_rx_pkg::*;
#(
   parameter int FIFO_DEPTH = 32,
   parameter int MIN_FRAME  = 64,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_bit,
   input  logic             carrier,
   input  logic             self_rx,
   input  logic             addr_miss,
   input  logic             no_buf,
   input  logic             coll,
   input  logic             rej_coll_en,
   input  logic             rej_err_en,
   input  logic             fifo_rd,
   output logic [7:0]       fifo_dout,
   output logic             fifo_empty,
   output logic [LVL_W-1:0] fifo_level,
   output logic             frame_done,
   output logic [4:0]       frame_stat
);

   localparam int CNT_W  = $clog2(MIN_FRAME + 1);
   localparam int PART_W = $clog2(OCT_W);

   if (MIN_FRAME < 1) begin : g_bad_min
      $error("mac_rx_framer: MIN_FRAME must be at least 1");
   end

   rx_state_e          state_q;
   logic               prev_q;
   logic               mon_q;
   logic               abort_q;
   logic               ovf_q;
   logic [CNT_W-1:0]   oct_cnt_q;
   rx_stat_t           stat_q;
   rx_stat_t           end_stat;
   logic               done_q;

   logic               sfd_hit;
   logic               take_bit;
   logic               frame_end;
   logic               hazard_now;
   logic               blocked;
   logic               want_wr;
   logic               fifo_wr;
   logic               ovf_now;
   logic               fifo_full;
   logic               oct_vld;
   logic [OCT_W-1:0]   oct_data;
   logic [PART_W-1:0]  part_cnt;
   logic               crc_good;

   assign sfd_hit    = carrier && (state_q == ST_HUNT) && prev_q && rx_bit;
   assign take_bit   = carrier && (state_q == ST_RECV);
   assign frame_end  = !carrier && (state_q == ST_RECV);
   assign hazard_now = addr_miss || no_buf || (coll && rej_coll_en);
   assign blocked    = abort_q || (take_bit && hazard_now);
   assign want_wr    = oct_vld && !mon_q && !blocked;
   assign fifo_wr    = want_wr && !fifo_full;
   assign ovf_now    = want_wr && fifo_full;

   rx_deser #(
      .W         (OCT_W),
      .LSB_FIRST (1'b1)
   ) i_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sfd_hit),
      .en       (take_bit),
      .din      (rx_bit),
      .oct_vld  (oct_vld),
      .oct_data (oct_data),
      .part_cnt (part_cnt)
   );

   rx_crc32_chk i_crc (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (sfd_hit),
      .en       (take_bit),
      .din      (rx_bit),
      .oct_last (oct_vld),
      .oct_good (crc_good)
   );

   rx_sync_fifo #(
      .W     (OCT_W),
      .DEPTH (FIFO_DEPTH)
   ) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (fifo_wr),
      .din   (oct_data),
      .rd    (fifo_rd),
      .dout  (fifo_dout),
      .empty (fifo_empty),
      .full  (fifo_full),
      .level (fifo_level)
   );

   always_comb begin
      end_stat.crc_err   = !crc_good;
      end_stat.align_err = (part_cnt != '0) && !crc_good;
      end_stat.runt      = (oct_cnt_q < CNT_W'(MIN_FRAME));
      end_stat.overrun   = ovf_q;
      end_stat.rejected  = abort_q || (rej_err_en && (!crc_good || end_stat.runt));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_HUNT;
         prev_q    <= 1'b0;
         mon_q     <= 1'b0;
         abort_q   <= 1'b0;
         ovf_q     <= 1'b0;
         oct_cnt_q <= '0;
         stat_q    <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!carrier) begin
            prev_q <= 1'b0;
            if (state_q == ST_RECV) begin
               state_q <= ST_HUNT;
               stat_q  <= end_stat;
               done_q  <= 1'b1;
            end
         end else if (state_q == ST_HUNT) begin
            prev_q <= rx_bit;
            if (sfd_hit) begin
               state_q   <= ST_RECV;
               mon_q     <= self_rx;
               abort_q   <= 1'b0;
               ovf_q     <= 1'b0;
               oct_cnt_q <= '0;
               stat_q    <= '0;
            end
         end else begin
            if (hazard_now) abort_q <= 1'b1;
            if (ovf_now) begin
               ovf_q   <= 1'b1;
               abort_q <= 1'b1;
            end
            if (oct_vld && oct_cnt_q != CNT_W'(MIN_FRAME)) begin
               oct_cnt_q <= oct_cnt_q + 1'b1;
            end
         end
      end
   end

   assign frame_done = done_q;
   assign frame_stat = stat_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done); // R3
   AST_DONE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> ($past(state_q) == ST_RECV && !$past(carrier))); // R3
   AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      sfd_hit |=> (frame_stat == '0)); // R12
   AST_MONITOR_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RECV && mon_q) |=> (fifo_level <= $past(fifo_level))); // R11
   AST_ALIGN_WITH_CRC: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stat[1] |-> frame_stat[0]); // R5
   AST_OVERRUN_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stat[3] |-> frame_stat[4]); // R7

endmodule

// File: tb/test_mac_rx_framer.sv
module test_mac_rx_framer;

   localparam int CLK_P = 10;
   localparam int DEPTH = 32;
   localparam int MINF  = 64;

   logic       clk;
   logic       rst_n;
   logic       rx_bit;
   logic       carrier;
   logic       self_rx;
   logic       addr_miss;
   logic       no_buf;
   logic       coll;
   logic       rej_coll_en;
   logic       rej_err_en;
   logic       fifo_rd;
   logic [7:0] fifo_dout;
   logic       fifo_empty;
   logic [5:0] fifo_level;
   logic       frame_done;
   logic [4:0] frame_stat;

   int n_chk  = 0;
   int n_fail = 0;
   int done_cnt = 0;
   int rcv_n = 0;
   int frm_n = 0;
   logic rd_en = 1'b0;
   logic [7:0] frm [0:127];
   logic [7:0] rcv [0:127];

   mac_rx_framer i_mac_rx_framer (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_bit      (rx_bit),
      .carrier     (carrier),
      .self_rx     (self_rx),
      .addr_miss   (addr_miss),
      .no_buf      (no_buf),
      .coll        (coll),
      .rej_coll_en (rej_coll_en),
      .rej_err_en  (rej_err_en),
      .fifo_rd     (fifo_rd),
      .fifo_dout   (fifo_dout),
      .fifo_empty  (fifo_empty),
      .fifo_level  (fifo_level),
      .frame_done  (frame_done),
      .frame_stat  (frame_stat)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_P / 2) clk = ~clk;
   end

   // FIFO drain process
   initial begin
      fifo_rd = 1'b0;
      forever begin
         @(negedge clk);
         if (rd_en && !fifo_empty && rcv_n < 128) begin
            rcv[rcv_n] = fifo_dout;
            rcv_n++;
            fifo_rd = 1'b1;
         end else begin
            fifo_rd = 1'b0;
         end
      end
   end

   // done strobe counter
   initial begin
      forever begin
         @(negedge clk);
         if (frame_done) done_cnt++;
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL all: watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] st(input bit rej, input bit ovf, input bit runt,
                                     input bit aln, input bit crc);
      return {rej, ovf, runt, aln, crc};
   endfunction

   task automatic build(input int pay, input int seed, input bit bad);
      logic [31:0] c;
      logic        fb;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < pay; i++) begin
         frm[i] = 8'(seed * 13 + i * 29 + 5);
         for (int b = 0; b < 8; b++) begin
            fb = c[0] ^ frm[i][b];
            c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
         end
      end
      c = ~c;
      for (int k = 0; k < 4; k++) frm[pay + k] = c[8*k +: 8];
      frm_n = pay + 4;
      if (bad) frm[2] = frm[2] ^ 8'h40;
   endtask

   task automatic drive_bit(input logic b);
      @(negedge clk);
      carrier = 1'b1;
      rx_bit  = b;
   endtask

   task automatic send_pre();
      for (int k = 0; k < 7; k++)
         for (int b = 0; b < 8; b++) drive_bit(b % 2 == 0);
      for (int b = 0; b < 6; b++) drive_bit(b % 2 == 0);
      drive_bit(1'b1);
      drive_bit(1'b1);
   endtask

   task automatic send_body();
      for (int i = 0; i < frm_n; i++)
         for (int b = 0; b < 8; b++) drive_bit(frm[i][b]);
   endtask

   task automatic send_tail(input int extra);
      for (int e = 0; e < extra; e++) drive_bit(e % 3 == 0);
   endtask

   task automatic end_frame(output logic d, output logic [4:0] s);
      @(negedge clk);
      carrier = 1'b0;
      rx_bit  = 1'b0;
      @(negedge clk);
      d = frame_done;
      s = frame_stat;
      repeat (3) @(negedge clk);
   endtask

   task automatic full_frame(input int extra, output logic d, output logic [4:0] s);
      send_pre();
      send_body();
      send_tail(extra);
      end_frame(d, s);
   endtask

   task automatic cmp_bytes(input string tag, input int n);
      int bad;
      bad = 0;
      for (int i = 0; i < n; i++) if (rcv[i] !== frm[i]) bad++;
      chk(tag, 32'(bad), 32'd0);
   endtask

   initial begin
      logic       d;
      logic [4:0] s;
      int         dc;
      rst_n = 1'b0; rx_bit = 1'b0; carrier = 1'b0; self_rx = 1'b0;
      addr_miss = 1'b0; no_buf = 1'b0; coll = 1'b0;
      rej_coll_en = 1'b0; rej_err_en = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 reset done", 32'(frame_done), 32'd0);
      chk("R3 reset status", 32'(frame_stat), 32'd0);
      chk("R2 reset empty", 32'(fifo_empty), 32'd1);
      chk("R2 reset level", 32'(fifo_level), 32'd0);

      // Sweep around the runt boundary with every tail length, good check sequence
      rd_en = 1'b1;
      for (int len = 60; len < 68; len++) begin
         for (int extra = 0; extra < 8; extra++) begin
            rcv_n = 0;
            dc = done_cnt;
            build(len - 4, len * 8 + extra, 1'b0);
            full_frame(extra, d, s);
            chk("R3 done strobe", 32'(d), 32'd1);
            chk("R3 single strobe", 32'(done_cnt - dc), 32'd1);
            chk("R6 R4 R5 status good", 32'(s), 32'(st(0, 0, len < MINF, 0, 0)));
            chk("R2 octet count", 32'(rcv_n), 32'(len));
            cmp_bytes("R2 byte order", len);
         end
      end

      // Corrupted frames: check error, alignment depends on tail
      for (int extra = 0; extra < 8; extra++) begin
         rcv_n = 0;
         build(66, 40 + extra, 1'b1);
         full_frame(extra, d, s);
         chk("R4 R5 status bad", 32'(s), 32'(st(0, 0, 0, extra != 0, 1)));
      end

      // No delimiter: alternating bits only, status keeps previous value
      begin
         logic [4:0] prev_s;
         prev_s = frame_stat;
         dc = done_cnt;
         for (int k = 0; k < 40; k++) drive_bit(k % 2 == 0);
         end_frame(d, s);
         chk("R1 no done", 32'(done_cnt - dc), 32'd0);
         chk("R1 status held", 32'(s), 32'(prev_s));
         chk("R1 fifo empty", 32'(fifo_empty), 32'd1);
      end

      // Clear on delimiter
      build(60, 3, 1'b0);
      send_pre();
      @(posedge clk);
      #(CLK_P / 4);
      chk("R12 cleared at delimiter", 32'(frame_stat), 32'd0);
      rcv_n = 0;
      send_body();
      end_frame(d, s);
      chk("R12 good after clear", 32'(s), 32'd0);

      // Error reject policy
      rej_err_en = 1'b1;
      rcv_n = 0;
      build(70, 9, 1'b1);
      full_frame(0, d, s);
      chk("R10 crc rejects", 32'(s), 32'(st(1, 0, 0, 0, 1)));
      chk("R10 octets still written", 32'(rcv_n), 32'd74);
      rcv_n = 0;
      build(36, 11, 1'b0);
      full_frame(0, d, s);
      chk("R10 runt rejects", 32'(s), 32'(st(1, 0, 1, 0, 0)));
      rej_err_en = 1'b0;

      // Monitor mode
      rd_en = 1'b0;
      self_rx = 1'b1;
      build(60, 21, 1'b0);
      full_frame(0, d, s);
      chk("R11 monitor good status", 32'(s), 32'd0);
      chk("R11 monitor no fill", 32'(fifo_level), 32'd0);
      build(60, 22, 1'b1);
      full_frame(3, d, s);
      chk("R11 monitor bad status", 32'(s), 32'(st(0, 0, 0, 1, 1)));
      chk("R11 monitor still empty", 32'(fifo_empty), 32'd1);
      self_rx = 1'b0;
      rd_en = 1'b1;

      // Address mismatch and buffer exhaustion
      addr_miss = 1'b1;
      rcv_n = 0;
      build(60, 30, 1'b0);
      full_frame(0, d, s);
      chk("R8 miss status", 32'(s), 32'(st(1, 0, 0, 0, 0)));
      chk("R8 miss no writes", 32'(rcv_n), 32'd0);
      addr_miss = 1'b0;
      no_buf = 1'b1;
      rcv_n = 0;
      full_frame(0, d, s);
      chk("R8 nobuf status", 32'(s), 32'(st(1, 0, 0, 0, 0)));
      chk("R8 nobuf no writes", 32'(rcv_n), 32'd0);
      no_buf = 1'b0;

      // Collision policy
      coll = 1'b1;
      rcv_n = 0;
      full_frame(0, d, s);
      chk("R9 coll ignored status", 32'(s), 32'd0);
      chk("R9 coll ignored writes", 32'(rcv_n), 32'd64);
      rej_coll_en = 1'b1;
      rcv_n = 0;
      full_frame(0, d, s);
      chk("R9 coll reject status", 32'(s), 32'(st(1, 0, 0, 0, 0)));
      chk("R9 coll reject writes", 32'(rcv_n), 32'd0);
      coll = 1'b0;
      rej_coll_en = 1'b0;

      // Overrun
      rd_en = 1'b0;
      rcv_n = 0;
      build(66, 50, 1'b0);
      full_frame(0, d, s);
      chk("R7 overrun status", 32'(s), 32'(st(1, 1, 0, 0, 0)));
      chk("R7 fifo full level", 32'(fifo_level), 32'(DEPTH));
      rd_en = 1'b1;
      repeat (80) @(negedge clk);
      chk("R7 kept octets", 32'(rcv_n), 32'(DEPTH));
      cmp_bytes("R7 kept bytes", DEPTH);
      chk("R7 drained", 32'(fifo_empty), 32'd1);

      summary();
      $finish;
   end

endmodule